// File: doc/BRIEF.md
# Dual-Mode Display Line FIFO

This block sits between a DMA engine that fetches display data from memory and the pixel pipeline that consumes it. A single word-wide storage area of `DEPTH` words serves two organisations. With the scan-mode input low it is one FIFO that uses the whole storage. With the scan-mode input high it is two independent FIFOs of `DEPTH/2` words each, one per panel half. Each FIFO has its own read port, which presents the head word before it is popped.

Each FIFO keeps a registered fill count. It raises its own DMA request while that count is below a programmable threshold, so the DMA engine tops each half up independently. Writes to a full FIFO and reads from an empty one are discarded and recorded in sticky per-FIFO flags. A package helper computes the recommended threshold from the DMA burst length.

Top module: `scan_line_fifo`

## Requirements
- R1: With `scan_dual` low, the storage is one FIFO of DEPTH (512) words. Every write goes to it whatever `wr_sel` is. Words leave in write order on `rd_data_lo`, which shows the oldest word before `rd_en_lo` pops it.
- R2: With `scan_dual` high, there are two independent FIFOs of DEPTH/2 (256) words each. `wr_sel`=0 writes the lower FIFO (`rd_*_lo`) and `wr_sel`=1 writes the upper FIFO (`rd_*_hi`). Each FIFO keeps its own order and its own contents.
- R3: `fill_lo` and `fill_hi` give the number of words held. They change on the clock edge that takes a push or a pop. A push and a pop accepted in the same cycle leave the count unchanged.
- R4: `dma_req_lo` is high exactly while `fill_lo` < `threshold`, and `dma_req_hi` is high exactly while `fill_hi` < `threshold` in dual mode. In single mode `dma_req_hi` is low and `fill_hi` is 0.
- R5: A write to a full FIFO is discarded even if that FIFO pops in the same cycle. It sets a sticky overflow bit (bit 0 for the lower or single FIFO, bit 1 for the upper FIFO), which only reset clears.
- R6: A read from an empty FIFO changes nothing and sets a sticky underflow bit, using the same bit order as R5. In single mode `rd_en_hi` is ignored and never sets underflow bit 1.
- R7: In a cycle where `scan_dual` differs from the mode held inside the block, every write and read is discarded. On the next cycle both fill counts are 0 and the new mode applies. The sticky flags keep their values.
- R8: The package function `dma_threshold(depth, burst)` returns depth − (2·burst + 3): 477 for 512 and 16, and 493 for 512 and 8.
- R9: After reset both fill counts and all flags are 0 and the block is in single mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_dual | input | 1 | 0 = one FIFO, 1 = two half-size FIFOs |
| threshold | input | CNT_W (10) | Request threshold in words |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | Target FIFO in dual mode (0 lower, 1 upper) |
| wr_data | input | DATA_W (32) | Write word |
| rd_en_lo | input | 1 | Pop lower/single FIFO |
| rd_data_lo | output | DATA_W (32) | Head word of lower/single FIFO |
| rd_en_hi | input | 1 | Pop upper FIFO |
| rd_data_hi | output | DATA_W (32) | Head word of upper FIFO |
| fill_lo | output | CNT_W (10) | Words in lower/single FIFO |
| fill_hi | output | CNT_W (10) | Words in upper FIFO |
| dma_req_lo | output | 1 | Refill request, lower/single FIFO |
| dma_req_hi | output | 1 | Refill request, upper FIFO |
| overflow | output | 2 | Sticky write-when-full flags |
| underflow | output | 2 | Sticky read-when-empty flags |

## Verification
The assertions rely on `scan_dual` being the only cause of a flush, and they expect `threshold` to stay within 0..DEPTH so that the request compare is meaningful. The stimulus changes `threshold` and `scan_dual` only between traffic phases, never inside a fill or drain sweep. Every word written is distinct, so a lost, duplicated or misrouted word shows up in the data checks. The stimulus deliberately drives past full and past empty, because the discard rules are part of the behaviour under test.

// File: rtl/slf_pkg.sv
package slf_pkg;

    localparam int DATA_W_DEF = 32;
    localparam int DEPTH_DEF  = 512;

    typedef enum logic {
        SCAN_SINGLE = 1'b0,
        SCAN_DUAL   = 1'b1
    } scan_mode_e;

    typedef struct packed {
        logic push;
        logic pop;
    } lane_cmd_t;

    typedef struct packed {
        logic ovf;
        logic unf;
    } lane_flag_t;

    // Recommended request threshold for a given storage depth and burst size
    function automatic int unsigned dma_threshold(input int unsigned depth,
                                                  input int unsigned burst);
        return depth - (2 * burst + 3);
    endfunction

endpackage

// File: rtl/slf_mem.sv
module slf_mem #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 512,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic [ADDR_W-1:0] raddr_b,
    output logic [DATA_W-1:0] rdata_b
);
    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    assign rdata_a = store[raddr_a];
    assign rdata_b = store[raddr_b];
endmodule

// File: rtl/slf_lane.sv
module slf_lane
    import slf_pkg::*;
#(
    parameter int DEPTH = 512,
    parameter int PTR_W = $clog2(DEPTH),
    parameter int CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic [CNT_W-1:0] cap,
    input  lane_cmd_t        cmd,
    output logic [CNT_W-1:0] count,
    output logic [PTR_W-1:0] wptr,
    output logic [PTR_W-1:0] rptr,
    output logic             push_ok,
    output lane_flag_t       flags
);
    logic full, empty, pop_ok;

    assign full    = (count == cap);
    assign empty   = (count == '0);
    assign push_ok = cmd.push && !full;
    assign pop_ok  = cmd.pop && !empty;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p,
                                             input logic [CNT_W-1:0] lim);
        return ({1'b0, p} == lim - CNT_W'(1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            count <= '0;
            wptr  <= '0;
            rptr  <= '0;
        end else begin
            if (push_ok) wptr <= bump(wptr, cap);
            if (pop_ok)  rptr <= bump(rptr, cap);
            count <= count + CNT_W'(push_ok) - CNT_W'(pop_ok);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else begin
            if (cmd.push && full) flags.ovf <= 1'b1;
            if (cmd.pop && empty) flags.unf <= 1'b1;
        end
    end

    assert_count_cap_R3: assert property (@(posedge clk) disable iff (rst)
        count <= cap);
    assert_full_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (cmd.push && !cmd.pop && full && !flush) |=> (count == $past(count)));
    assert_empty_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (cmd.pop && !cmd.push && empty && !flush) |=> (count == '0));
    assert_flush_clear_R7: assert property (@(posedge clk) disable iff (rst)
        flush |=> (count == '0));
    assert_sticky_ovf_R5: assert property (@(posedge clk) disable iff (rst)
        flags.ovf |=> flags.ovf);
    assert_sticky_unf_R6: assert property (@(posedge clk) disable iff (rst)
        flags.unf |=> flags.unf);
endmodule

// File: rtl/scan_line_fifo.sv
module scan_line_fifo
    import slf_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF,
    parameter int DEPTH  = DEPTH_DEF,
    parameter int PTR_W  = $clog2(DEPTH),
    parameter int CNT_W  = PTR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scan_dual,
    input  logic [CNT_W-1:0]  threshold,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en_lo,
    output logic [DATA_W-1:0] rd_data_lo,
    input  logic              rd_en_hi,
    output logic [DATA_W-1:0] rd_data_hi,
    output logic [CNT_W-1:0]  fill_lo,
    output logic [CNT_W-1:0]  fill_hi,
    output logic              dma_req_lo,
    output logic              dma_req_hi,
    output logic [1:0]        overflow,
    output logic [1:0]        underflow
);
    localparam int HALF  = DEPTH / 2;
    localparam int LANES = 2;

    scan_mode_e       mode_q;
    logic             flush, dual;
    logic [CNT_W-1:0] cap;

    lane_cmd_t        cmd   [LANES];
    lane_flag_t       flg   [LANES];
    logic [CNT_W-1:0] cnt   [LANES];
    logic [PTR_W-1:0] wp    [LANES];
    logic [PTR_W-1:0] rp    [LANES];
    logic             pushd [LANES];

    always_ff @(posedge clk) begin
        if (rst) mode_q <= SCAN_SINGLE;
        else     mode_q <= scan_mode_e'(scan_dual);
    end

    assign flush = (scan_mode_e'(scan_dual) != mode_q);
    assign dual  = (mode_q == SCAN_DUAL);
    assign cap   = dual ? CNT_W'(HALF) : CNT_W'(DEPTH);

    // Routing of the write and read strobes to the two lanes
    always_comb begin
        cmd[0].push = wr_en && !flush && (!dual || !wr_sel);
        cmd[0].pop  = rd_en_lo && !flush;
        cmd[1].push = wr_en && !flush && dual && wr_sel;
        cmd[1].pop  = rd_en_hi && !flush && dual;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        slf_lane #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_lane (
            .clk     (clk),
            .rst     (rst),
            .flush   (flush),
            .cap     (cap),
            .cmd     (cmd[g]),
            .count   (cnt[g]),
            .wptr    (wp[g]),
            .rptr    (rp[g]),
            .push_ok (pushd[g]),
            .flags   (flg[g])
        );
        assign overflow[g]  = flg[g].ovf;
        assign underflow[g] = flg[g].unf;
    end

    // The upper lane lives in the top half of the shared storage
    logic              mem_we;
    logic [PTR_W-1:0]  mem_waddr, raddr_hi;

    assign mem_we    = pushd[0] || pushd[1];
    assign mem_waddr = pushd[1] ? (PTR_W'(HALF) + wp[1]) : wp[0];
    assign raddr_hi  = PTR_W'(HALF) + rp[1];

    slf_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(PTR_W)) u_mem (
        .clk     (clk),
        .we      (mem_we),
        .waddr   (mem_waddr),
        .wdata   (wr_data),
        .raddr_a (rp[0]),
        .rdata_a (rd_data_lo),
        .raddr_b (raddr_hi),
        .rdata_b (rd_data_hi)
    );

    assign fill_lo    = cnt[0];
    assign fill_hi    = cnt[1];
    assign dma_req_lo = (cnt[0] < threshold);
    assign dma_req_hi = dual && (cnt[1] < threshold);

    assert_hi_idle_R4: assert property (@(posedge clk) disable iff (rst)
        (mode_q == SCAN_SINGLE) |-> (fill_hi == '0 && !dma_req_hi));
    assert_single_writer_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !flush) |-> $onehot0({pushd[1], pushd[0]}));
    assert_hi_cap_R2: assert property (@(posedge clk) disable iff (rst)
        dual |-> (fill_hi <= CNT_W'(HALF)));
endmodule

// File: tb/scan_line_fifo_tb.sv
`timescale 1ns/1ps
module scan_line_fifo_tb;
    import slf_pkg::*;

    localparam int DW  = 32;
    localparam int DEP = 512;
    localparam int CW  = 10;

    logic          clk = 1'b0;
    logic          rst;
    logic          scan_dual;
    logic [CW-1:0] threshold;
    logic          wr_en, wr_sel, rd_en_lo, rd_en_hi;
    logic [DW-1:0] wr_data;
    logic [DW-1:0] rd_data_lo, rd_data_hi;
    logic [CW-1:0] fill_lo, fill_hi;
    logic          dma_req_lo, dma_req_hi;
    logic [1:0]    overflow, underflow;

    always #2 clk = ~clk;

    scan_line_fifo u_dut (
        .clk(clk), .rst(rst), .scan_dual(scan_dual), .threshold(threshold),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_en_lo(rd_en_lo), .rd_data_lo(rd_data_lo),
        .rd_en_hi(rd_en_hi), .rd_data_hi(rd_data_hi),
        .fill_lo(fill_lo), .fill_hi(fill_hi),
        .dma_req_lo(dma_req_lo), .dma_req_hi(dma_req_hi),
        .overflow(overflow), .underflow(underflow)
    );

    int n_chk = 0;
    int n_bad = 0;

    logic [DW-1:0] q0 [$];
    logic [DW-1:0] q1 [$];
    bit   m_dual = 1'b0;
    bit   [1:0] m_ovf = '0, m_unf = '0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_state();
        int cap;
        cap = m_dual ? DEP/2 : DEP;
        chk(fill_lo == CW'(q0.size()), "R3", "fill_lo", fill_lo, q0.size());
        chk(fill_hi == CW'(q1.size()), "R3", "fill_hi", fill_hi, q1.size());
        chk(dma_req_lo == (q0.size() < int'(threshold)), "R4", "dma_req_lo",
            dma_req_lo, q0.size() < int'(threshold));
        chk(dma_req_hi == (m_dual && q1.size() < int'(threshold)), "R4", "dma_req_hi",
            dma_req_hi, m_dual && q1.size() < int'(threshold));
        chk(overflow == m_ovf, "R5", "overflow", overflow, m_ovf);
        chk(underflow == m_unf, "R6", "underflow", underflow, m_unf);
        chk(q0.size() <= cap, "R1", "model cap", q0.size(), cap);
    endtask

    // One clock of traffic; the model follows the requirements
    task automatic cyc(input bit we, input bit sel, input logic [DW-1:0] d,
                       input bit rlo, input bit rhi);
        bit p0, p1, r0, r1, f0, f1, e0, e1;
        int cap;
        wr_en = we; wr_sel = sel; wr_data = d; rd_en_lo = rlo; rd_en_hi = rhi;
        if (scan_dual != m_dual) begin
            @(posedge clk); #1;
            q0.delete(); q1.delete(); m_dual = scan_dual;
        end else begin
            cap = m_dual ? DEP/2 : DEP;
            p0 = we && (!m_dual || !sel);
            p1 = we && m_dual && sel;
            r0 = rlo;
            r1 = rhi && m_dual;
            f0 = (q0.size() == cap); f1 = (q1.size() == cap);
            e0 = (q0.size() == 0);   e1 = (q1.size() == 0);
            if (r0 && !e0) chk(rd_data_lo == q0[0], m_dual ? "R2" : "R1",
                               "rd_data_lo", rd_data_lo, q0[0]);
            if (r1 && !e1) chk(rd_data_hi == q1[0], "R2", "rd_data_hi",
                               rd_data_hi, q1[0]);
            @(posedge clk); #1;
            if (r0 && !e0) void'(q0.pop_front());
            if (r1 && !e1) void'(q1.pop_front());
            if (p0) begin if (f0) m_ovf[0] = 1'b1; else q0.push_back(d); end
            if (p1) begin if (f1) m_ovf[1] = 1'b1; else q1.push_back(d); end
            if (r0 && e0) m_unf[0] = 1'b1;
            if (r1 && e1) m_unf[1] = 1'b1;
        end
        wr_en = 0; rd_en_lo = 0; rd_en_hi = 0;
        compare_state();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1; scan_dual = 0; threshold = 10'd477;
        wr_en = 0; wr_sel = 0; wr_data = '0; rd_en_lo = 0; rd_en_hi = 0;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R9 reset state
        chk(fill_lo == 0 && fill_hi == 0, "R9", "fills after reset", {fill_hi, fill_lo}, 0);
        chk(overflow == 0 && underflow == 0, "R9", "flags after reset",
            {overflow, underflow}, 0);
        chk(dma_req_lo == 1 && dma_req_hi == 0, "R9", "requests after reset",
            {dma_req_hi, dma_req_lo}, 1);

        // R8 helper values computed arithmetically
        for (int b = 1; b <= 32; b++)
            chk(dma_threshold(512, b) == 512 - 2*b - 3, "R8", "dma_threshold",
                dma_threshold(512, b), 512 - 2*b - 3);
        chk(dma_threshold(512, 16) == 477, "R8", "burst 16", dma_threshold(512, 16), 477);

        // R1 single mode: fill with wr_sel toggling, then one write past full
        for (int i = 0; i < DEP; i++) cyc(1, i[0], 32'hA000_0000 + i, 0, 0);
        chk(fill_lo == 10'd512, "R1", "single full", fill_lo, 512);
        cyc(1, 0, 32'hDEAD_0001, 0, 0);
        chk(overflow == 2'b01, "R5", "overflow lower", overflow, 1);
        cyc(1, 1, 32'hDEAD_0002, 1, 0);   // write at full with pop: still discarded (R5)
        chk(fill_lo == 10'd511, "R5", "full push+pop", fill_lo, 511);
        // drain, upper port strobed and ignored (R6)
        for (int i = 0; i < DEP - 1; i++) cyc(0, 0, '0, 1, 1);
        chk(underflow == 2'b00, "R6", "upper read ignored in single", underflow, 0);
        cyc(0, 0, '0, 1, 0);
        chk(underflow == 2'b01, "R6", "underflow lower", underflow, 1);
        // simultaneous push and pop keep the count (R3)
        cyc(1, 0, 32'hB000_0000, 0, 0);
        for (int i = 1; i < 40; i++) cyc(1, 0, 32'hB000_0000 + i, 1, 0);
        chk(fill_lo == 10'd1, "R3", "steady count", fill_lo, 1);

        // R7 switch to dual, write in the switch cycle is dropped
        threshold = 10'd200;
        scan_dual = 1;
        cyc(1, 0, 32'hDEAD_0003, 1, 1);
        chk(fill_lo == 0 && fill_hi == 0, "R7", "flush to dual", {fill_hi, fill_lo}, 0);
        chk(underflow == 2'b01, "R7", "flags kept", underflow, 1);

        // R2 dual mode: interleaved fill beyond both capacities
        for (int i = 0; i < DEP + 8; i++)
            cyc(1, i[0], (i[0] ? 32'hC100_0000 : 32'hC000_0000) + (i >> 1), 0, 0);
        chk(fill_lo == 10'd256 && fill_hi == 10'd256, "R2", "half capacity",
            {fill_hi, fill_lo}, {10'd256, 10'd256});
        chk(overflow == 2'b11, "R5", "overflow both", overflow, 3);
        // drain lower faster than upper to show independence
        for (int i = 0; i < 256; i++) cyc(0, 0, '0, 1, i[0]);
        for (int i = 0; i < 129; i++) cyc(0, 0, '0, 0, 1);
        chk(underflow == 2'b11, "R6", "underflow both", underflow, 3);
        for (int i = 0; i < 300; i++) cyc(1, i[1], 32'hE000_0000 + i, i[2], i[3]);

        // R7 back to single with data present
        for (int i = 0; i < 10; i++) cyc(1, 0, 32'hF000_0000 + i, 0, 0);
        scan_dual = 0;
        cyc(1, 1, 32'hDEAD_0004, 0, 0);
        chk(fill_lo == 0 && fill_hi == 0, "R7", "flush to single", {fill_hi, fill_lo}, 0);
        for (int i = 0; i < 20; i++) cyc(1, 1, 32'h1234_0000 + i, i[0], 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule